// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Wide Instruction Register

This block is the slave side of a boundary-scan test port. An external tester drives a test clock, a mode-select line and serial data in. The block walks the standard sixteen-state test-port controller and, depending on the controller state, shifts either a 32-bit instruction register or one of its data registers between serial data in and serial data out. The data registers are a one-bit bypass register and a 32-bit identification register that returns a fixed device code.

The instruction register is unusually wide: every opcode is a full 32-bit pattern. The identification opcode selects the identification register. Two bypass opcodes, all zeros and all ones, select the bypass register. Four boundary-scan opcodes (external test, sample/preload, high-impedance and clamp) are decoded and reported on status outputs; the boundary cell chain they would drive lives outside this block, so they shift through the bypass register. An opcode not in the list also behaves as bypass. Reset comes from a power-on reset and from the mode-select line; there is no separate test reset pin.

Top module: `scan_tap_port`

## Requirements
- R1: While and after power-on reset the controller is in Test-Logic-Reset, `tdo_en` is 0, all four status outputs are 0, and the active instruction is the identification opcode.
- R2: Five consecutive test-clock rising edges with `tms` high bring the controller to Test-Logic-Reset from any state, and on entry the active instruction becomes the identification opcode (status outputs all 0).
- R3: `tms` and `tdi` are sampled on the rising edge of `tck`; `tdo` and `tdo_en` change on the falling edge. `tdo_en` is 1 exactly while the controller is in Shift-IR or Shift-DR, and `tdo` is 0 while `tdo_en` is 0.
- R4: The instruction register is 32 bits, shifts in from `tdi` least significant bit first and shifts out from its bit 0; Capture-IR loads 0x00000001, which is the first 32 bits seen on `tdo` during an instruction scan.
- R5: A newly shifted instruction takes effect only on the rising edge that leaves Update-IR; during Shift-IR and Exit1-IR the status outputs keep the previous instruction's values.
- R6: Opcode 0xFFFFFFFE selects the identification register, which captures 0x000DF2FF in Capture-DR and shifts it out least significant bit first; bits beyond the 32nd are `tdi` delayed by 32 clocks.
- R7: Opcodes 0x00000000 and 0xFFFFFFFF select the bypass register, which captures 0 in Capture-DR, so a data scan returns 0 followed by `tdi` delayed by one clock.
- R8: Opcodes 0xFFFFFFE8, 0xFFFFFFF8, 0xFFFFFFCF and 0xFFFFFFEF raise `st_extest`, `st_sample`, `st_highz` and `st_clamp` respectively, never more than one at a time, and data scans under them use the bypass register.
- R9: Any opcode not listed in R6 to R8 selects the bypass register and leaves all status outputs at 0.
- R10: `tms` high in a shift state moves the controller to the matching Exit1 state; from Exit1-DR, `tms` low enters Pause-DR, which holds the data register, and from Exit2-DR `tms` low resumes shifting at the next bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge of `tck` |
| tdi | input | 1 | Serial data in, sampled on the rising edge of `tck` |
| tdo | output | 1 | Serial data out, updated on the falling edge of `tck` |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| st_extest | output | 1 | External-test instruction active |
| st_sample | output | 1 | Sample/preload instruction active |
| st_highz | output | 1 | High-impedance instruction active |
| st_clamp | output | 1 | Clamp instruction active |

## Verification
The hardest situation to reach is the five-ones reset from an arbitrary controller state with a non-identification instruction loaded, since every path through the state graph differs in how many of those five edges it spends in transit. The stimulus loads a boundary-scan opcode, wanders the controller through a random-length walk of random `tms` values, then applies five ones and checks that the status outputs clear and that the next data scan returns the identification code. A second hard spot is the Pause-DR detour in the middle of a data scan, reached with a directed sequence that stops after sixteen bits, idles in pause, and resumes through Exit2-DR.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

   typedef enum logic [3:0] {
      TS_EX2_DR = 4'h0,
      TS_EX1_DR = 4'h1,
      TS_SH_DR  = 4'h2,
      TS_PAU_DR = 4'h3,
      TS_SEL_IR = 4'h4,
      TS_UPD_DR = 4'h5,
      TS_CAP_DR = 4'h6,
      TS_SEL_DR = 4'h7,
      TS_EX2_IR = 4'h8,
      TS_EX1_IR = 4'h9,
      TS_SH_IR  = 4'hA,
      TS_PAU_IR = 4'hB,
      TS_IDLE   = 4'hC,
      TS_UPD_IR = 4'hD,
      TS_CAP_IR = 4'hE,
      TS_RESET  = 4'hF
   } tap_state_e;

   typedef struct packed {
      logic idcode;
      logic bypass;
      logic extest;
      logic sample;
      logic highz;
      logic clamp;
   } instr_sel_t;

   function automatic tap_state_e tap_next(tap_state_e s, logic m);
      tap_state_e n;
      case (s)
         TS_RESET:  n = m ? TS_RESET  : TS_IDLE;
         TS_IDLE:   n = m ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR: n = m ? TS_EX1_DR : TS_SH_DR;
         TS_SH_DR:  n = m ? TS_EX1_DR : TS_SH_DR;
         TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
         TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
         TS_EX2_DR: n = m ? TS_UPD_DR : TS_SH_DR;
         TS_UPD_DR: n = m ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR: n = m ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR: n = m ? TS_EX1_IR : TS_SH_IR;
         TS_SH_IR:  n = m ? TS_EX1_IR : TS_SH_IR;
         TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
         TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
         TS_EX2_IR: n = m ? TS_UPD_IR : TS_SH_IR;
         TS_UPD_IR: n = m ? TS_SEL_DR : TS_IDLE;
         default:   n = TS_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_e st,
   output tap_state_e st_nxt
);

   tap_state_e st_q;

   always_comb st_nxt = tap_next(st_q, tms);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) st_q <= TS_RESET;
      else        st_q <= st_nxt;
   end

   assign st = st_q;

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
   import scan_tap_pkg::*;
#(
   parameter int               IR_W      = 32,
   parameter logic [IR_W-1:0]  OP_IDCODE = 32'hFFFF_FFFE,
   parameter logic [IR_W-1:0]  OP_BYP_LO = 32'h0000_0000,
   parameter logic [IR_W-1:0]  OP_BYP_HI = 32'hFFFF_FFFF,
   parameter logic [IR_W-1:0]  OP_EXTEST = 32'hFFFF_FFE8,
   parameter logic [IR_W-1:0]  OP_SAMPLE = 32'hFFFF_FFF8,
   parameter logic [IR_W-1:0]  OP_HIGHZ  = 32'hFFFF_FFCF,
   parameter logic [IR_W-1:0]  OP_CLAMP  = 32'hFFFF_FFEF
)(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tdi,
   input  tap_state_e st,
   input  tap_state_e st_nxt,
   output logic       sr_lsb,
   output instr_sel_t sel
);

   localparam int              TOP = IR_W - 1;
   localparam logic [IR_W-1:0] CAPT_PAT = {{(IR_W-2){1'b0}}, 2'b01};

   logic [IR_W-1:0] sr_q;
   logic [IR_W-1:0] act_q;

   // serial shift path, LSB leaves first, tdi enters at the top
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) begin
         sr_q <= CAPT_PAT;
      end else begin
         case (st)
            TS_CAP_IR: sr_q <= CAPT_PAT;
            TS_SH_IR:  sr_q <= {tdi, sr_q[TOP:1]};
            default:   sr_q <= sr_q;
         endcase
      end
   end

   // active instruction: forced on entry to reset, loaded when leaving update
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                  act_q <= OP_IDCODE;
      else if (st_nxt == TS_RESET) act_q <= OP_IDCODE;
      else if (st == TS_UPD_IR)    act_q <= sr_q;
   end

   always_comb begin
      sel = '0;
      if (act_q == OP_IDCODE)                            sel.idcode = 1'b1;
      else if (act_q == OP_BYP_LO || act_q == OP_BYP_HI) sel.bypass = 1'b1;
      else if (act_q == OP_EXTEST)                       sel.extest = 1'b1;
      else if (act_q == OP_SAMPLE)                       sel.sample = 1'b1;
      else if (act_q == OP_HIGHZ)                        sel.highz  = 1'b1;
      else if (act_q == OP_CLAMP)                        sel.clamp  = 1'b1;
      else                                               sel.bypass = 1'b1;
   end

   assign sr_lsb = sr_q[0];

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
   import scan_tap_pkg::*;
#(
   parameter int              ID_W       = 32,
   parameter logic [ID_W-1:0] IDCODE_VAL = 32'h000D_F2FF,
   parameter bit              HAS_IDCODE = 1'b1
)(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tdi,
   input  tap_state_e st,
   input  logic       sel_id,
   input  logic       sel_byp,
   output logic       dr_lsb
);

   localparam int TOP = ID_W - 1;

   logic byp_q;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)              byp_q <= 1'b0;
      else if (st == TS_CAP_DR) byp_q <= 1'b0;
      else if (st == TS_SH_DR)  byp_q <= tdi;
   end

   generate
      if (HAS_IDCODE) begin : g_id
         logic [ID_W-1:0] id_q;
         always_ff @(posedge tck or negedge por_n) begin
            if (!por_n)               id_q <= IDCODE_VAL;
            else if (st == TS_CAP_DR) id_q <= IDCODE_VAL;
            else if (st == TS_SH_DR)  id_q <= {tdi, id_q[TOP:1]};
         end
         assign dr_lsb = (sel_id && !sel_byp) ? id_q[0] : byp_q;
      end else begin : g_noid
         assign dr_lsb = (sel_id && !sel_byp) ? 1'b0 : byp_q;
      end
   endgenerate

endmodule

// File: rtl/scan_tap_out.sv
module scan_tap_out
   import scan_tap_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  tap_state_e st,
   input  logic       ir_bit,
   input  logic       dr_bit,
   output logic       tdo,
   output logic       tdo_en
);

   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= (st == TS_SH_IR) || (st == TS_SH_DR);
         case (st)
            TS_SH_IR: tdo <= ir_bit;
            TS_SH_DR: tdo <= dr_bit;
            default:  tdo <= 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/scan_tap_port.sv
module scan_tap_port
   import scan_tap_pkg::*;
#(
   parameter int               IR_W       = 32,
   parameter int               ID_W       = 32,
   parameter logic [ID_W-1:0]  IDCODE_VAL = 32'h000D_F2FF,
   parameter bit               HAS_IDCODE = 1'b1,
   parameter logic [IR_W-1:0]  OP_IDCODE  = 32'hFFFF_FFFE,
   parameter logic [IR_W-1:0]  OP_BYP_LO  = 32'h0000_0000,
   parameter logic [IR_W-1:0]  OP_BYP_HI  = 32'hFFFF_FFFF,
   parameter logic [IR_W-1:0]  OP_EXTEST  = 32'hFFFF_FFE8,
   parameter logic [IR_W-1:0]  OP_SAMPLE  = 32'hFFFF_FFF8,
   parameter logic [IR_W-1:0]  OP_HIGHZ   = 32'hFFFF_FFCF,
   parameter logic [IR_W-1:0]  OP_CLAMP   = 32'hFFFF_FFEF
)(
   input  logic tck,
   input  logic por_n,
   input  logic tms,
   input  logic tdi,
   output logic tdo,
   output logic tdo_en,
   output logic st_extest,
   output logic st_sample,
   output logic st_highz,
   output logic st_clamp
);

   localparam int MIN_IR_W = 2;

   generate
      if (IR_W < MIN_IR_W) begin : g_bad_irw
         $error("instruction register must be at least two bits");
      end
      if (IDCODE_VAL[0] != 1'b1) begin : g_bad_id
         $error("identification code must have bit 0 set");
      end
      if (OP_IDCODE == OP_BYP_LO || OP_IDCODE == OP_BYP_HI) begin : g_bad_op
         $error("identification opcode collides with a bypass opcode");
      end
   endgenerate

   tap_state_e tap_st;
   tap_state_e tap_nxt;
   instr_sel_t sel;
   logic       ir_bit;
   logic       dr_bit;

   scan_tap_fsm u_fsm (
      .tck    (tck),
      .por_n  (por_n),
      .tms    (tms),
      .st     (tap_st),
      .st_nxt (tap_nxt)
   );

   scan_tap_ir #(
      .IR_W      (IR_W),
      .OP_IDCODE (OP_IDCODE),
      .OP_BYP_LO (OP_BYP_LO),
      .OP_BYP_HI (OP_BYP_HI),
      .OP_EXTEST (OP_EXTEST),
      .OP_SAMPLE (OP_SAMPLE),
      .OP_HIGHZ  (OP_HIGHZ),
      .OP_CLAMP  (OP_CLAMP)
   ) u_ir (
      .tck    (tck),
      .por_n  (por_n),
      .tdi    (tdi),
      .st     (tap_st),
      .st_nxt (tap_nxt),
      .sr_lsb (ir_bit),
      .sel    (sel)
   );

   scan_tap_dr #(
      .ID_W       (ID_W),
      .IDCODE_VAL (IDCODE_VAL),
      .HAS_IDCODE (HAS_IDCODE)
   ) u_dr (
      .tck     (tck),
      .por_n   (por_n),
      .tdi     (tdi),
      .st      (tap_st),
      .sel_id  (sel.idcode),
      .sel_byp (sel.bypass),
      .dr_lsb  (dr_bit)
   );

   scan_tap_out u_out (
      .tck    (tck),
      .por_n  (por_n),
      .st     (tap_st),
      .ir_bit (ir_bit),
      .dr_bit (dr_bit),
      .tdo    (tdo),
      .tdo_en (tdo_en)
   );

   assign st_extest = sel.extest;
   assign st_sample = sel.sample;
   assign st_highz  = sel.highz;
   assign st_clamp  = sel.clamp;

endmodule

// File: rtl/scan_tap_port_chk.sv
module scan_tap_port_chk
   import scan_tap_pkg::*;
(
   input logic       tck,
   input logic       por_n,
   input logic       tms,
   input logic       tdo_en,
   input tap_state_e st,
   input logic [3:0] status
);

   logic [2:0] ones_q;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)              ones_q <= 3'd0;
      else if (!tms)           ones_q <= 3'd0;
      else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
   end

   AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!por_n)
      (ones_q == 3'd5) |-> (st == TS_RESET)); // R2

   AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (!por_n)
      tdo_en |-> (st == TS_SH_IR || st == TS_SH_DR)); // R3

   AST_TDO_EN_PRESENT: assert property (@(posedge tck) disable iff (!por_n)
      (st == TS_SH_IR || st == TS_SH_DR) |-> tdo_en); // R3

   AST_STATUS_ONEHOT: assert property (@(posedge tck) disable iff (!por_n)
      $onehot0(status)); // R8

   AST_STATUS_HOLD: assert property (@(posedge tck) disable iff (!por_n)
      ($past(st) != TS_UPD_IR && st != TS_RESET) |-> $stable(status)); // R5

   AST_SHIFT_EXIT: assert property (@(posedge tck) disable iff (!por_n)
      ((st == TS_SH_DR || st == TS_SH_IR) && tms) |=> (st == TS_EX1_DR || st == TS_EX1_IR)); // R10

   AST_PAUSE_ENTRY: assert property (@(posedge tck) disable iff (!por_n)
      (st == TS_EX1_DR && !tms) |=> (st == TS_PAU_DR)); // R10

endmodule

bind scan_tap_port scan_tap_port_chk u_chk (
   .tck    (tck),
   .por_n  (por_n),
   .tms    (tms),
   .tdo_en (tdo_en),
   .st     (tap_st),
   .status ({st_extest, st_sample, st_highz, st_clamp})
);

// File: tb/scan_tap_port_bench.sv
module scan_tap_port_bench;

   localparam logic [31:0] ID_VAL  = 32'h000D_F2FF;
   localparam logic [31:0] OP_ID   = 32'hFFFF_FFFE;
   localparam logic [31:0] OP_B0   = 32'h0000_0000;
   localparam logic [31:0] OP_B1   = 32'hFFFF_FFFF;
   localparam logic [31:0] OP_EXT  = 32'hFFFF_FFE8;
   localparam logic [31:0] OP_SMP  = 32'hFFFF_FFF8;
   localparam logic [31:0] OP_HZ   = 32'hFFFF_FFCF;
   localparam logic [31:0] OP_CLMP = 32'hFFFF_FFEF;

   logic tck = 1'b0;
   logic por_n = 1'b0;
   logic tms = 1'b1;
   logic tdi = 1'b0;
   logic tdo, tdo_en, st_extest, st_sample, st_highz, st_clamp;

   always #5 tck = ~tck;

   scan_tap_port u_scan_tap_port (
      .tck       (tck),
      .por_n     (por_n),
      .tms       (tms),
      .tdi       (tdi),
      .tdo       (tdo),
      .tdo_en    (tdo_en),
      .st_extest (st_extest),
      .st_sample (st_sample),
      .st_highz  (st_highz),
      .st_clamp  (st_clamp)
   );

   int   total = 0;
   int   bad = 0;
   bit   ended = 0;
   logic last_tdo;
   logic last_en;

   function automatic logic [3:0] stat_now();
      return {st_extest, st_sample, st_highz, st_clamp};
   endfunction

   function automatic logic [3:0] exp_stat(input logic [31:0] op);
      case (op)
         OP_EXT:  return 4'b1000;
         OP_SMP:  return 4'b0100;
         OP_HZ:   return 4'b0010;
         OP_CLMP: return 4'b0001;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic logic [63:0] exp_dr(input logic [31:0] op, input logic [63:0] din, input int n);
      logic [63:0] full;
      if (op == OP_ID) full = {din[31:0], ID_VAL};
      else             full = {din[62:0], 1'b0};
      if (n < 64) full = full & ((64'd1 << n) - 64'd1);
      return full;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic m, input logic d);
      tms = m;
      tdi = d;
      @(posedge tck);
      @(negedge tck);
      #1;
      last_tdo = tdo;
      last_en  = tdo_en;
   endtask

   task automatic load_ir(input logic [31:0] op, output logic [31:0] cap,
                          output logic [3:0] mid, output int en_err);
      cap = '0;
      en_err = 0;
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      cap[0] = last_tdo;
      if (!last_en) en_err++;
      for (int i = 0; i < 32; i++) begin
         step(i == 31, op[i]);
         if (i < 31) begin
            cap[i+1] = last_tdo;
            if (!last_en) en_err++;
         end else if (last_en || last_tdo) en_err++;
      end
      mid = stat_now();
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
   endtask

   task automatic scan_dr(input int n, input logic [63:0] din,
                          output logic [63:0] dout, output int en_err);
      dout = '0;
      en_err = 0;
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      dout[0] = last_tdo;
      if (!last_en) en_err++;
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i]);
         if (i < n - 1) begin
            dout[i+1] = last_tdo;
            if (!last_en) en_err++;
         end else if (last_en || last_tdo) en_err++;
      end
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
   endtask

   task automatic summary();
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   task automatic run_op(input logic [31:0] op, input int n, input logic [63:0] din,
                         inout logic [3:0] prev);
      logic [31:0] cap;
      logic [3:0]  mid;
      logic [63:0] dout;
      int          e1, e2;
      load_ir(op, cap, mid, e1);
      chk(cap == 32'h1, "R4 capture", {32'h0, cap}, 64'h1);
      chk(e1 == 0, "R3 ir enable", e1, 0);
      chk(mid == prev, "R5 hold", {60'h0, mid}, {60'h0, prev});
      chk(stat_now() == exp_stat(op), "R8/R9 status", {60'h0, stat_now()}, {60'h0, exp_stat(op)});
      scan_dr(n, din, dout, e2);
      if (op == OP_ID)
         chk(dout == exp_dr(op, din, n), "R6 idcode", dout, exp_dr(op, din, n));
      else if (op == OP_B0 || op == OP_B1)
         chk(dout == exp_dr(op, din, n), "R7 bypass", dout, exp_dr(op, din, n));
      else if (exp_stat(op) != 4'b0)
         chk(dout == exp_dr(op, din, n), "R8 bypass path", dout, exp_dr(op, din, n));
      else
         chk(dout == exp_dr(op, din, n), "R9 unlisted", dout, exp_dr(op, din, n));
      chk(e2 == 0, "R3 dr enable", e2, 0);
      prev = exp_stat(op);
   endtask

   initial begin
      repeat (200000) @(posedge tck);
      if (!ended) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
      end
   end

   initial begin
      logic [63:0] dout;
      logic [3:0]  prev;
      logic [31:0] pool [8];
      logic [31:0] cap;
      logic [3:0]  mid;
      int          e;
      void'($urandom(32'd5150));
      pool[0] = OP_ID;  pool[1] = OP_B0;  pool[2] = OP_B1;  pool[3] = OP_EXT;
      pool[4] = OP_SMP; pool[5] = OP_HZ;  pool[6] = OP_CLMP; pool[7] = 32'h1234_5678;

      repeat (3) @(negedge tck);
      #1;
      chk(tdo_en == 1'b0, "R1 en in reset", tdo_en, 0);
      por_n = 1'b1;
      @(negedge tck);
      #1;
      chk(tdo_en == 1'b0 && tdo == 1'b0, "R1 outputs", {tdo_en, tdo}, 0);
      chk(stat_now() == 4'b0, "R1 status", stat_now(), 0);
      step(1'b0, 1'b0);
      scan_dr(32, 64'h0, dout, e);
      chk(dout == {32'h0, ID_VAL}, "R1 idcode active", dout, {32'h0, ID_VAL});
      prev = 4'b0;

      // directed opcodes, including all-zero and all-one bypass and an unlisted one
      for (int k = 0; k < 8; k++)
         run_op(pool[k], 40, {$urandom, $urandom}, prev);
      run_op(32'h8000_0000, 33, {$urandom, $urandom}, prev);

      // constrained random opcodes and scan lengths
      for (int k = 0; k < 40; k++) begin
         logic [31:0] op;
         op = pool[$urandom_range(0, 7)];
         if ($urandom_range(0, 7) == 0) op = $urandom;
         run_op(op, $urandom_range(1, 64), {$urandom, $urandom}, prev);
      end

      // five-ones reset from a random walk, with a boundary opcode loaded first
      for (int k = 0; k < 12; k++) begin
         load_ir(OP_EXT, cap, mid, e);
         chk(stat_now() == 4'b1000, "R8 extest before walk", stat_now(), 4'b1000);
         for (int w = 0; w < int'($urandom_range(1, 30)); w++)
            step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
         for (int w = 0; w < 5; w++) step(1'b1, $urandom_range(0, 1) == 1);
         chk(stat_now() == 4'b0 && !tdo_en, "R2 reset status", {tdo_en, stat_now()}, 0);
         step(1'b0, 1'b0);
         scan_dr(32, {$urandom, $urandom}, dout, e);
         chk(dout == {32'h0, ID_VAL}, "R2 idcode after reset", dout, {32'h0, ID_VAL});
      end
      prev = 4'b0;

      // pause in the middle of an identification scan
      load_ir(OP_ID, cap, mid, e);
      dout = '0;
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      dout[0] = last_tdo;
      for (int i = 0; i < 16; i++) begin
         step(i == 15, 1'b0);
         if (i < 15) dout[i+1] = last_tdo;
      end
      step(1'b0, 1'b0);
      chk(!tdo_en, "R10 pause disables", tdo_en, 0);
      repeat (3) step(1'b0, 1'b1);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      dout[16] = last_tdo;
      chk(tdo_en, "R10 resume enables", tdo_en, 1);
      for (int i = 16; i < 32; i++) begin
         step(i == 31, 1'b0);
         if (i < 31) dout[i+1] = last_tdo;
      end
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      chk(dout == {32'h0, ID_VAL}, "R10 pause keeps data", dout, {32'h0, ID_VAL});

      summary();
   end

endmodule